// File: doc/BRIEF.md
# Symmetrical Offset Segment Decoder

This block turns one channel's 16-bit two's-complement audio sample into the switch controls of a segmented current-steering converter. The upper part of the code selects how many of 32 equal coarse current slots are switched on, as a thermometer pattern that grows from slot 0 upward. The lower 11 bits go straight to the binary switches of a fine divider fed from one further source.

The mapping is shifted by half a coarse segment, so that bipolar zero sits in the middle of a segment rather than on a segment edge. Stepping from 0 to -1, or back, therefore changes only the fine bits and never a coarse slot. The cost is that the top half-segment of positive codes saturates at full scale. The decoded pattern is captured in output registers on a load strobe and then held. In a stereo design one instance serves each channel, and the two strobes are tied together so that both channels update on the same edge.

Top module: `symoff_seg_decoder`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first load, `coarse_en` is 0x0000FFFF (slots 0 to 15 on) and `fine_bits` is 0x400, which is the decode of a zero sample.
- R2: Outputs change only on a rising clock edge where `load` is high. On every other edge they keep their value, whatever `sample` does.
- R3: For a captured sample x, the level is L = (x XOR 0x8000) + 1024. The coarse count is L[15:11] and `fine_bits` is L[10:0]. Both take effect at the clock edge that captures the load.
- R4: `coarse_en` is a thermometer code: bit i is 1 exactly when i is below the coarse count. Bit 31 is never set.
- R5: Samples 0x0000 and 0xFFFF give identical `coarse_en`. Their `fine_bits` are 0x400 and 0x3FF.
- R6: Any positive sample at or above 0x7C00 saturates to full scale: 31 slots on and `fine_bits` all ones.
- R7: The most negative sample, 0x8000, gives no coarse slots and `fine_bits` 0x400.
- R8: Outside saturation, the weighted total (coarse slots on times 2048, plus `fine_bits`) equals L. Loading x+1 right after x raises the total by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to the bipolar-zero pattern |
| load | input | 1 | Capture strobe; the decoded sample is registered on this edge |
| sample | input | 16 | Two's-complement input sample |
| coarse_en | output | 32 | Thermometer enables of the coarse current slots |
| fine_bits | output | 11 | Binary switch controls of the fine divider |

## Verification
The bench goes after the 0 / -1 pair. A decoder without the half-segment shift would move slot 15 there, which is exactly the zero-crossing glitch this block exists to remove. It drives the saturation edge at 0x7BFF / 0x7C00 and the most negative code: a wrap-around in the offset adder would show up there as a near-zero output for a full-scale input. Back-to-back ramps across segment edges catch an off-by-one in the thermometer compare, which would give a jump of 2048 instead of 1. Idle stretches with a moving sample catch a register that follows its input without waiting for the strobe.

// File: rtl/symoff_pkg.sv
package symoff_pkg;

    // Region of the shifted level: inside the usable range or clipped at the top
    typedef enum logic [0:0] {
        REG_NORMAL    = 1'b0,
        REG_SATURATED = 1'b1
    } level_region_e;

    localparam int DEF_SAMPLE_W    = 16;
    localparam int DEF_COARSE_BITS = 5;

endpackage

// File: rtl/symoff_offset_map.sv
module symoff_offset_map
    import symoff_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int FINE_W   = SAMPLE_W - DEF_COARSE_BITS
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SAMPLE_W-1:0] level,
    output level_region_e       region
);
    localparam int HALF_SEG = 2 ** (FINE_W - 1);

    logic [SAMPLE_W-1:0] unsigned_code;
    logic [SAMPLE_W:0]   shifted;

    always_comb begin
        // Sign flip gives offset binary; half a segment centres zero in a segment
        unsigned_code = {~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0]};
        shifted       = {1'b0, unsigned_code} + (SAMPLE_W+1)'(HALF_SEG);
        if (shifted[SAMPLE_W]) begin
            region = REG_SATURATED;
            level  = '1;
        end else begin
            region = REG_NORMAL;
            level  = shifted[SAMPLE_W-1:0];
        end
    end
endmodule

// File: rtl/symoff_thermo.sv
module symoff_thermo #(
    parameter int COARSE_BITS = 5,
    parameter int SLOTS       = 2 ** COARSE_BITS
) (
    input  logic [COARSE_BITS-1:0] count,
    output logic [SLOTS-1:0]       enables
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        // Slot i is on when more than i slots are requested
        assign enables[i] = (count > COARSE_BITS'(i));
    end
endmodule

// File: rtl/symoff_out_reg.sv
module symoff_out_reg #(
    parameter int                  SLOTS  = 32,
    parameter int                  FINE_W = 11,
    parameter logic [SLOTS-1:0]    RST_COARSE = '0,
    parameter logic [FINE_W-1:0]   RST_FINE   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOTS-1:0]  coarse_d,
    input  logic [FINE_W-1:0] fine_d,
    output logic [SLOTS-1:0]  coarse_q,
    output logic [FINE_W-1:0] fine_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_q <= RST_COARSE;
            fine_q   <= RST_FINE;
        end else if (load) begin
            coarse_q <= coarse_d;
            fine_q   <= fine_d;
        end
    end

    // R2: no strobe, no change
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(coarse_q) && $stable(fine_q)));
endmodule

// File: rtl/symoff_seg_decoder.sv
module symoff_seg_decoder
    import symoff_pkg::*;
#(
    parameter int SAMPLE_W    = DEF_SAMPLE_W,
    parameter int COARSE_BITS = DEF_COARSE_BITS
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 load,
    input  logic [SAMPLE_W-1:0]                  sample,
    output logic [(2**COARSE_BITS)-1:0]          coarse_en,
    output logic [SAMPLE_W-COARSE_BITS-1:0]      fine_bits
);
    localparam int SLOTS     = 2 ** COARSE_BITS;
    localparam int FINE_W    = SAMPLE_W - COARSE_BITS;
    localparam int HALF_SEG  = 2 ** (FINE_W - 1);
    localparam logic [SLOTS-1:0]  RST_COARSE = {{(SLOTS/2){1'b0}}, {(SLOTS/2){1'b1}}};
    localparam logic [FINE_W-1:0] RST_FINE   = FINE_W'(HALF_SEG);
    localparam logic [SAMPLE_W-1:0] SAT_START = SAMPLE_W'(2 ** (SAMPLE_W - 1) - HALF_SEG);
    localparam logic [SAMPLE_W-1:0] MOST_NEG  = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [SAMPLE_W-1:0] level;
    level_region_e       region;
    logic [SLOTS-1:0]    coarse_d;

    symoff_offset_map #(.SAMPLE_W(SAMPLE_W), .FINE_W(FINE_W)) u_map (
        .sample (sample),
        .level  (level),
        .region (region)
    );

    symoff_thermo #(.COARSE_BITS(COARSE_BITS), .SLOTS(SLOTS)) u_thermo (
        .count   (level[SAMPLE_W-1:FINE_W]),
        .enables (coarse_d)
    );

    symoff_out_reg #(
        .SLOTS(SLOTS), .FINE_W(FINE_W),
        .RST_COARSE(RST_COARSE), .RST_FINE(RST_FINE)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .coarse_d (coarse_d),
        .fine_d   (level[FINE_W-1:0]),
        .coarse_q (coarse_en),
        .fine_q   (fine_bits)
    );

    // Weighted output total seen at the ports
    logic [31:0] out_total;
    always_comb out_total = 32'($countones(coarse_en)) * (32'd1 << FINE_W) + 32'(fine_bits);

    // R4: contiguous from slot 0, top slot never driven
    assert_thermo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((coarse_en & (coarse_en + 1'b1)) == '0) && !coarse_en[SLOTS-1]);

    // R6: positive codes in the top half-segment clip to full scale
    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sample[SAMPLE_W-1] && sample >= SAT_START)
        |=> (fine_bits == '1 && $countones(coarse_en) == SLOTS - 1));

    // R6: the mapper flags exactly the clipped range
    assert_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_SATURATED) |-> (!sample[SAMPLE_W-1] && sample >= SAT_START));

    // R5: stepping 0 -> -1 leaves every coarse slot alone
    assert_zero_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && $past(load) && sample == '1 && $past(sample) == '0)
        |=> $stable(coarse_en));

    // R8: unit step in input gives unit step in weighted total
    assert_unit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && $past(load) && sample == $past(sample) + 1'b1
         && sample != MOST_NEG && $signed(sample) < $signed(SAT_START))
        |=> (out_total == $past(out_total) + 32'd1));
endmodule

// File: tb/symoff_seg_decoder_bench.sv
module symoff_seg_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] sample = 16'h0000;
    logic [31:0] coarse_en;
    logic [10:0] fine_bits;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] s;
        logic [31:0] c;
        logic [10:0] f;
        logic [16:0] lvl;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    symoff_seg_decoder u_symoff_seg_decoder (
        .clk(clk), .rst_n(rst_n), .load(load), .sample(sample),
        .coarse_en(coarse_en), .fine_bits(fine_bits)
    );

    function automatic exp_t model(input logic [15:0] x, input string req);
        exp_t e;
        logic [16:0] v;
        int cnt;
        v = {1'b0, x ^ 16'h8000} + 17'd1024;
        if (v[16]) v = 17'h0FFFF;
        cnt = int'(v[15:11]);
        e.s = x;
        e.c = 32'((64'd1 << cnt) - 64'd1);
        e.f = v[10:0];
        e.lvl = v;
        e.req = req;
        return e;
    endfunction

    task automatic check(input string req, input logic [15:0] s,
                         input logic [31:0] gc, input logic [31:0] ec,
                         input logic [10:0] gf, input logic [10:0] ef);
        checks++;
        if (gc !== ec || gf !== ef) begin
            failures++;
            $display("FAIL %s sample=%h coarse got %h exp %h fine got %h exp %h",
                     req, s, gc, ec, gf, ef);
        end
    endtask

    task automatic drive(input logic [15:0] x, input string req);
        @(negedge clk);
        sample = x;
        load = 1'b1;
        sb.push_back(model(x, req));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            load = 1'b0;
        end
    endtask

    // Monitor: pops one expected item per strobed edge
    initial begin
        forever begin
            logic lw;
            exp_t e;
            @(posedge clk);
            lw = load;
            #1;
            if (lw && rst_n) begin
                if (sb.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R2 unexpected strobe got %h exp none", coarse_en);
                end else begin
                    e = sb.pop_front();
                    check(e.req, e.s, coarse_en, e.c, fine_bits, e.f);
                    // R8: weighted total equals the shifted level
                    checks++;
                    if (($countones(coarse_en) * 2048 + int'(fine_bits)) != int'(e.lvl[15:0])) begin
                        failures++;
                        $display("FAIL R8 sample=%h total got %0d exp %0d", e.s,
                                 $countones(coarse_en) * 2048 + int'(fine_bits), e.lvl[15:0]);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        exp_t z;
        logic [31:0] c_zero;
        logic [15:0] lfsr;
        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        check("R1", 16'h0000, coarse_en, 32'h0000FFFF, fine_bits, 11'h400);
        rst_n = 1'b1;
        sample = 16'h5A5A;
        idle(2);
        check("R1", 16'h5A5A, coarse_en, 32'h0000FFFF, fine_bits, 11'h400);

        // R5: zero crossing pair, back to back
        drive(16'h0000, "R5");
        drive(16'hFFFF, "R5");
        idle(1);
        z = model(16'h0000, "R5");
        c_zero = z.c;
        check("R5", 16'hFFFF, coarse_en, c_zero, fine_bits, 11'h3FF);
        drive(16'h0000, "R5");
        idle(1);

        // R7: most negative end
        drive(16'h8000, "R7");
        drive(16'h8001, "R7");
        idle(1);
        check("R7", 16'h8001, coarse_en, 32'h0, fine_bits, 11'h401);

        // R6: saturation edge and interior
        drive(16'h7BFE, "R3");
        drive(16'h7BFF, "R6");
        drive(16'h7C00, "R6");
        drive(16'h7D55, "R6");
        drive(16'h7FFF, "R6");
        idle(1);
        check("R6", 16'h7FFF, coarse_en, 32'h7FFFFFFF, fine_bits, 11'h7FF);

        // R4 / R8: ramps across segment edges
        for (int k = -3; k <= 3; k++) drive(16'(16'h03FF + k), "R4");
        for (int k = -3; k <= 3; k++) drive(16'(16'hFBFF + k), "R8");
        for (int k = -2; k <= 2; k++) drive(16'(16'h8400 + k), "R8");
        idle(1);

        // R2: sample moves while load stays low
        drive(16'h1234, "R3");
        idle(1);
        z = model(16'h1234, "R2");
        sample = 16'h8000;
        idle(2);
        sample = 16'h7FFF;
        idle(2);
        check("R2", 16'h1234, coarse_en, z.c, fine_bits, z.f);

        // R3: pseudo-random samples
        lfsr = 16'hACE1;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr, "R3");
            if (n % 7 == 3) idle(1);
        end
        idle(2);

        // R1: reset in mid-run returns to bipolar zero
        drive(16'h6000, "R3");
        idle(1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 16'h6000, coarse_en, 32'h0000FFFF, fine_bits, 11'h400);
        rst_n = 1'b1;
        idle(2);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule